// File: doc/BRIEF.md
# Wiper Position Register with I2C Slave Access

This block holds the tap position of a 128-step digital potentiometer and lets a host on a two-wire I2C bus write and read that position. SCL and SDA are oversampled by the system clock, so the bus runs much slower than the core. The block recognises START and STOP, matches a fixed 7-bit device identity and accepts a one-byte register address. It then either loads the wiper from a data byte or streams the wiper value back to the host.

The SDA output is an open-drain pull-down enable. The pad or bench resolves the line as the wired-AND of the host and this enable. The wiper output feeds the tap-select decoder of the resistor array and comes out of reset at midscale.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper output is 64 (0x40, midscale) and the SDA pull-down is off.
- R2: A START is SDA falling while SCL is high. Bits clocked while the block is idle, with no START seen, are not acknowledged and do not change the wiper.
- R3: The first byte after a START is sent MSB first. Its upper seven bits must equal 0101000 and bit 0 selects the direction (0 = write, 1 = read). A matching byte is acknowledged by pulling SDA low during the ninth clock. A non-matching byte is not acknowledged, and the rest of that transaction is ignored.
- R4: After a write identity byte, only the address byte 0x00 is acknowledged. Any other value gets no acknowledge, and the data that follows does not reach the wiper.
- R5: Each data byte of a write is acknowledged. Its lower seven bits become the wiper value and bit 7 is discarded.
- R6: The new wiper value appears after the falling SCL edge that ends the eighth data bit. While SCL is still high for that bit, the old value is still shown.
- R7: A read is a write identity byte (0x50), address 0x00, a repeated START and a read identity byte (0x51). All three are acknowledged. The block then drives the byte {0, wiper} MSB first.
- R8: After a read byte, a master ACK (SDA low in the ninth clock) makes the block send the wiper byte again. A master NACK makes it release SDA and go idle.
- R9: A STOP (SDA rising while SCL is high) releases SDA and makes the block idle until the next START.
- R10: The block changes its SDA drive only while SCL is low, so it never creates a START or STOP itself.
- R11: Several data bytes in one write transaction are each acknowledged and each loaded, so the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper_o | output | 7 | Current tap position |

## Verification
The bench targets the timing of the wiper load. A design that loads on the ACK clock, or while the eighth bit is still high, shows the wrong value at the probe inside the eighth clock or just after it. Transactions with a wrong identity, a non-zero address, or no START at all must leave the wiper unchanged and get no acknowledge. A design that only resets its bit counter on START would acknowledge stray bytes. Reads are checked over an ACK-ACK-NACK run, which exposes a design that stops after one byte, that keeps driving after the NACK, or that leaks bit 7 of a stored byte. Every driven bit is sampled at both ends of the SCL high phase, so a drive change during the high phase is caught.

// File: rtl/wiper_pkg.sv
// Package: shared constants and the protocol state type for the wiper slave.
// Assumes byte-wide bus transfers with one acknowledge clock per byte.
package wiper_pkg;
    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVID,
        ST_REGADDR,
        ST_WRDATA,
        ST_RDDATA
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL/SDA into the clock domain and flags edges and bus
// conditions. Assumes the bus is slower than clk by a wide margin, so that
// every SCL level lasts many clk cycles. Lines reset to the idle-high level.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_lvl   = scl_ff[STAGES-1];
        sda_lvl   = sda_ff[STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/wiper_bus_ctrl.sv
// Module: byte-level protocol engine. It counts bits, matches the identity
// and address, raises a load pulse for write data and shifts read data out.
// Assumes edge flags are one-cycle pulses from i2c_line_sync.
module wiper_bus_ctrl
    import wiper_pkg::*;
#(
    parameter int          WIPER_W  = 7,
    parameter logic [6:0]  DEV_ID   = 7'b0101000,
    parameter logic [7:0]  REG_ADDR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_lvl,
    input  logic [WIPER_W-1:0] wiper_q,
    output logic               sda_low,
    output logic               load_en,
    output logic [WIPER_W-1:0] load_val
);
    localparam int PAD_W = BYTE_BITS - WIPER_W;

    bus_state_t               state;
    bus_state_t               follow_st;
    bus_state_t               after_ack;
    logic [BIT_CNT_W-1:0]     bit_cnt;
    logic                     ack_ph;
    logic                     slave_ack;
    logic                     host_ack;
    logic [BYTE_BITS-1:0]     rx_sh;
    logic [BYTE_BITS-1:0]     tx_sh;
    logic [BYTE_BITS-1:0]     rd_byte;

    // State that follows the ninth clock of the current byte.
    always_comb begin
        rd_byte = {{PAD_W{1'b0}}, wiper_q};
        if (state == ST_RDDATA) after_ack = host_ack ? ST_RDDATA : ST_IDLE;
        else                    after_ack = follow_st;
    end

    // Protocol sequencing on bus conditions and SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            follow_st <= ST_IDLE;
            bit_cnt   <= '0;
            ack_ph    <= 1'b0;
            slave_ack <= 1'b0;
            host_ack  <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_en   <= 1'b0;
            load_val  <= '0;
        end else begin
            load_en <= 1'b0;
            if (start_det || stop_det) begin
                state     <= start_det ? ST_DEVID : ST_IDLE;
                bit_cnt   <= '0;
                ack_ph    <= 1'b0;
                slave_ack <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (ack_ph) begin
                        host_ack <= ~sda_lvl;
                    end else if (bit_cnt < BIT_CNT_W'(BYTE_BITS)) begin
                        rx_sh   <= {rx_sh[BYTE_BITS-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (ack_ph) begin
                        ack_ph    <= 1'b0;
                        slave_ack <= 1'b0;
                        bit_cnt   <= '0;
                        state     <= after_ack;
                        if (after_ack == ST_RDDATA) tx_sh <= rd_byte;
                    end else if (bit_cnt == BIT_CNT_W'(BYTE_BITS)) begin
                        unique case (state)
                            ST_DEVID: begin
                                if (rx_sh[7:1] == DEV_ID) begin
                                    slave_ack <= 1'b1;
                                    ack_ph    <= 1'b1;
                                    follow_st <= rx_sh[0] ? ST_RDDATA : ST_REGADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_REGADDR: begin
                                if (rx_sh == REG_ADDR) begin
                                    slave_ack <= 1'b1;
                                    ack_ph    <= 1'b1;
                                    follow_st <= ST_WRDATA;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_WRDATA: begin
                                load_en   <= 1'b1;
                                load_val  <= rx_sh[WIPER_W-1:0];
                                slave_ack <= 1'b1;
                                ack_ph    <= 1'b1;
                                follow_st <= ST_WRDATA;
                            end
                            ST_RDDATA: begin
                                ack_ph <= 1'b1;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end else if (state == ST_RDDATA) begin
                        tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // Pull-down: own acknowledge, or a zero data bit while sending.
    always_comb begin
        sda_low = slave_ack |
                  ((state == ST_RDDATA) && !ack_ph && !tx_sh[BYTE_BITS-1]);
    end
endmodule

// File: rtl/wiper_store.sv
// Module: the volatile wiper register with its midscale preset.
// Assumes load_en is a single-cycle pulse.
module wiper_store #(
    parameter int               WIPER_W = 7,
    parameter logic [WIPER_W-1:0] PRESET  = 7'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [WIPER_W-1:0] load_val,
    output logic [WIPER_W-1:0] wiper_q
);
    // Hold the tap position, preset at reset, reload on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       wiper_q <= PRESET;
        else if (load_en) wiper_q <= load_val;
    end
endmodule

// File: rtl/wiper_i2c_slave.sv
// Module: top level of the bus-controlled wiper register. It joins the line
// synchronizer, the protocol engine and the wiper store. Assumes an external
// open-drain pad that resolves sda_pull_low_o with the other bus drivers.
module wiper_i2c_slave #(
    parameter int         TAPS        = 128,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ID      = 7'b0101000,
    parameter logic [7:0] REG_ADDR    = 8'h00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_pull_low_o,
    output logic [$clog2(TAPS)-1:0]  wiper_o
);
    localparam int                 WIPER_W = $clog2(TAPS);
    localparam logic [WIPER_W-1:0] PRESET  = WIPER_W'(TAPS / 2);

    logic               scl_lvl;
    logic               sda_lvl;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    logic               load_en;
    logic [WIPER_W-1:0] load_val;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    wiper_bus_ctrl #(.WIPER_W(WIPER_W), .DEV_ID(DEV_ID), .REG_ADDR(REG_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_lvl(sda_lvl), .wiper_q(wiper_o),
        .sda_low(sda_pull_low_o), .load_en(load_en), .load_val(load_val)
    );

    wiper_store #(.WIPER_W(WIPER_W), .PRESET(PRESET)) u_store (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_val(load_val), .wiper_q(wiper_o)
    );
endmodule

// File: rtl/wiper_i2c_slave_chk.sv
// Module: property checker bound into wiper_i2c_slave. It watches the ports
// and the synchronized bus flags of the top level.
module wiper_i2c_slave_chk #(
    parameter int WIPER_W = 7,
    parameter logic [WIPER_W-1:0] PRESET = 7'h40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_lvl,
    input logic               scl_fall,
    input logic               stop_det,
    input logic               sda_pull_low_o,
    input logic [WIPER_W-1:0] wiper_o
);
    // Leaving reset shows midscale and a released line.
    assert_reset_preset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wiper_o == PRESET && !sda_pull_low_o));

    // A wiper change traces back to a falling SCL edge two cycles earlier.
    assert_load_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o != $past(wiper_o)) |-> $past(scl_fall, 2));

    // A STOP leaves the line released.
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_low_o);

    // The pull-down only starts while SCL is low.
    assert_drive_in_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low_o) |-> !scl_lvl);

    // The pull-down only ends while SCL is low, except on a STOP.
    assert_release_in_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_low_o) |-> (!scl_lvl || $past(stop_det)));
endmodule

bind wiper_i2c_slave wiper_i2c_slave_chk #(.WIPER_W(WIPER_W), .PRESET(PRESET)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .stop_det(stop_det), .sda_pull_low_o(sda_pull_low_o), .wiper_o(wiper_o)
);

// File: tb/wiper_i2c_slave_tb_top.sv
// Directed bench: a bus master model with open-drain line resolution.
module wiper_i2c_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       pull_low;
    logic [6:0] wiper;
    logic       sda_line;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~pull_low;

    wiper_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_low_o(pull_low), .wiper_o(wiper)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(6);
        m_scl = 1'b1; wait_clk(8);
        m_sda = 1'b0; wait_clk(8);
        m_scl = 1'b0; wait_clk(6);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(6);
        m_scl = 1'b1; wait_clk(8);
        m_sda = 1'b1; wait_clk(8);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wait_clk(6);
        m_scl = 1'b1; wait_clk(8);
        m_scl = 1'b0; wait_clk(6);
    endtask

    task automatic ack_clock(output logic ack);
        m_sda = 1'b1; wait_clk(6);
        m_scl = 1'b1; wait_clk(4);
        ack = !sda_line; wait_clk(4);
        m_scl = 1'b0; wait_clk(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_clock(ack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d, output logic steady);
        logic first;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wait_clk(6);
            m_scl = 1'b1; wait_clk(1);
            first = sda_line; wait_clk(6);
            d[i] = sda_line;
            if (first != d[i]) steady = 1'b0;
            wait_clk(1);
            m_scl = 1'b0; wait_clk(6);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wait_clk(6);
        m_scl = 1'b1; wait_clk(8);
        m_scl = 1'b0; wait_clk(6);
        m_sda = 1'b1;
    endtask

    task automatic write_wiper(input logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h00, a);
        send_byte(d, a);
        bus_stop();
    endtask

    // R1: preset after reset.
    task automatic t_reset();
        check(wiper == 7'h40, "R1 wiper preset", wiper, 7'h40);
        check(pull_low == 1'b0, "R1 sda released", pull_low, 0);
    endtask

    // R3 R4 R5: a plain write, then one with bit 7 set.
    task automatic t_write();
        logic a;
        bus_start();
        send_byte(8'h50, a); check(a, "R3 id ack", a, 1);
        send_byte(8'h00, a); check(a, "R4 addr ack", a, 1);
        send_byte(8'h25, a); check(a, "R5 data ack", a, 1);
        bus_stop();
        check(wiper == 7'h25, "R5 wiper load", wiper, 7'h25);
        write_wiper(8'hD3);
        check(wiper == 7'h53, "R5 bit7 dropped", wiper, 7'h53);
    endtask

    // R6: load point is the fall of the eighth data clock.
    task automatic t_commit_edge();
        logic a;
        logic [7:0] d = 8'h11;
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h00, a);
        for (int i = 7; i >= 1; i--) send_bit(d[i]);
        m_sda = d[0]; wait_clk(6);
        m_scl = 1'b1; wait_clk(8);
        check(wiper == 7'h53, "R6 old value in high phase", wiper, 7'h53);
        m_scl = 1'b0; wait_clk(6);
        check(wiper == 7'h11, "R6 new value after fall", wiper, 7'h11);
        ack_clock(a);
        check(a, "R6 data ack", a, 1);
        bus_stop();
    endtask

    // R3: wrong identity is not acknowledged, the rest is ignored.
    task automatic t_bad_id();
        logic a;
        bus_start();
        send_byte(8'h52, a); check(!a, "R3 wrong id nack", a, 0);
        send_byte(8'h00, a); check(!a, "R3 ignored addr", a, 0);
        send_byte(8'h7F, a); check(!a, "R3 ignored data", a, 0);
        bus_stop();
        check(wiper == 7'h11, "R3 wiper kept", wiper, 7'h11);
    endtask

    // R4: a non-zero address is refused.
    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'h50, a); check(a, "R4 id ack", a, 1);
        send_byte(8'h01, a); check(!a, "R4 addr 01 nack", a, 0);
        send_byte(8'h33, a); check(!a, "R4 data ignored", a, 0);
        bus_stop();
        check(wiper == 7'h11, "R4 wiper kept", wiper, 7'h11);
    endtask

    // R7 R8 R10: read with repeated START, ACK ACK NACK.
    task automatic t_read();
        logic a, st;
        logic [7:0] d;
        write_wiper(8'hAA);
        check(wiper == 7'h2A, "R5 preload", wiper, 7'h2A);
        bus_start();
        send_byte(8'h50, a); check(a, "R7 wr id ack", a, 1);
        send_byte(8'h00, a); check(a, "R7 addr ack", a, 1);
        bus_start();
        send_byte(8'h51, a); check(a, "R7 rd id ack", a, 1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k < 2, d, st);
            check(d == 8'h2A, "R7 read byte", d, 8'h2A);
            check(st, "R10 steady in high", st, 1);
        end
        check(pull_low == 1'b0, "R8 released after nack", pull_low, 0);
        bus_stop();
        check(pull_low == 1'b0, "R9 released after stop", pull_low, 0);
    endtask

    // R2 R9: after a STOP, bytes without a START are ignored.
    task automatic t_no_start();
        logic a;
        send_byte(8'h50, a); check(!a, "R2 no start id", a, 0);
        send_byte(8'h00, a); check(!a, "R9 idle addr", a, 0);
        send_byte(8'h05, a); check(!a, "R9 idle data", a, 0);
        bus_stop();
        check(wiper == 7'h2A, "R2 wiper kept", wiper, 7'h2A);
    endtask

    // R11: several data bytes in one write.
    task automatic t_multi();
        logic a;
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h00, a);
        send_byte(8'h10, a); check(a, "R11 first ack", a, 1);
        check(wiper == 7'h10, "R11 first load", wiper, 7'h10);
        send_byte(8'h6E, a); check(a, "R11 second ack", a, 1);
        bus_stop();
        check(wiper == 7'h6E, "R11 last wins", wiper, 7'h6E);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_write();
        t_commit_edge();
        t_bad_id();
        t_bad_addr();
        t_read();
        t_no_start();
        t_multi();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule